// File: doc/BRIEF.md
# Two-Channel Hardware Breakpoint Comparator

This block watches a processor's bus and raises a break request when a programmed condition matches. Every bus beat carries an address, a data value, a fetch/data flag, a read/write flag, byte-lane strobes, a valid strobe and a tag that names the instruction slot. A separate retire port reports completed instructions by tag, and a flush input marks a pipeline flush. The halt logic that consumes the break request lies outside this block.

The two channels have different capabilities. Channel 1 is a full comparator. It matches an address under a coarse mask, can require a fetch cycle or a data cycle, and can check the access size against the byte-lane strobes. It can also restrict the match to reads or to writes, and it can compare the data lanes that are active. Channel 2 compares only an exact address, and only on fetch cycles. It does not break at the fetch. It holds the fetch's tag and breaks once the instruction with that tag retires.

A simple register write port programs both channels. The outputs are a one-cycle break request and a sticky status bit for each channel. Software clears the status bits with write-one-to-clear.

Top module: `bkpt_unit`

Register map (index on `cfg_addr_i`). Index 0 is channel 1 control: bit 0 enable, bits 3:1 mask code, bits 5:4 cycle select, bits 7:6 size select, bits 9:8 read/write select, bit 10 data compare. Index 1 is the channel 1 address and index 2 the channel 1 data. Index 3 is channel 2 control, with bit 0 as enable. Index 4 is the channel 2 address. Index 5 is the status clear. Indices 6 and 7 have no effect.

## Requirements
- R1: Channel 1 mask codes 1 to 5 ignore the lowest 4, 8, 12, 16 or 20 address bits. Codes 0, 6 and 7 demand an exact match on all address bits.
- R2: The channel 1 cycle select uses these codes: 0 and 3 accept both fetch and data cycles, 1 accepts fetch cycles only (`bus_fetch_i`=1), and 2 accepts data cycles only.
- R3: The channel 1 size select uses these codes: 0 accepts any strobes, 1 requires `bus_be_i`=2'b01 (lower byte), 2 requires 2'b10 (upper byte), and 3 requires 2'b11 (word).
- R4: The channel 1 read/write select uses these codes: 0 and 3 accept both, 1 requires a read (`bus_write_i`=0), and 2 requires a write.
- R5: When the data compare bit is set, each byte lane whose strobe is active must equal the matching byte of the programmed data value. Lanes with an inactive strobe are not compared.
- R6: A channel 1 match on a valid beat drives `brk_req_o` high for the single cycle after that clock edge. A channel whose enable bit is clear never matches.
- R7: A channel 2 fetch beat whose address equals the programmed address raises no break. It records the beat's tag. The break is raised in the cycle after the first retire that carries that tag, and that retire consumes the pending match. Data beats never arm channel 2.
- R8: A flush, or any write to channel 2's control or address register, clears the pending channel 2 match. A retire in the same cycle as a flush raises no break.
- R9: Each channel sets its own sticky status bit when it matches, and both bits are set if both channels match in the same cycle. Writing 1s to index 5 clears the selected bits, and a match in the same cycle wins over the clear.
- R10: After reset, `brk_req_o` is 0, the status is 0 and both channels are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus beat valid |
| bus_fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_data_i | input | DATA_W | Bus data |
| bus_be_i | input | DATA_W/8 | Byte-lane strobes, bit 0 = lower byte |
| bus_tag_i | input | TAG_W | Instruction tag of a fetch beat |
| retire_valid_i | input | 1 | An instruction retires |
| retire_tag_i | input | TAG_W | Tag of the retiring instruction |
| flush_i | input | 1 | Pipeline flush |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register index |
| cfg_wdata_i | input | 32 | Register write data |
| brk_req_o | output | 1 | Break request pulse |
| brk_status_o | output | 2 | Sticky per-channel match status, bit 0 = channel 1 |

## Verification
The assertions assume that inputs are driven to known values on every cycle once reset is released. They also assume that the byte-lane strobes describe a real access. The properties tie each break back to the qualifiers that were active one cycle earlier, so any input that is X would make those properties vacuous. The stimulus changes inputs only on the falling clock edge and returns every strobe to idle between operations. Random addresses are drawn from a small pool around the programmed addresses, and retire tags come from a small tag range, so that matches, mask hits and tag hits occur often, while a pending fetch and a later flush or reconfiguration still land in separate cycles.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [1:0] {CYC_ANY, CYC_FETCH, CYC_DATA, CYC_ANY_ALT} cyc_sel_e;
  typedef enum logic [1:0] {SZ_ANY, SZ_LO, SZ_HI, SZ_WORD} size_sel_e;
  typedef enum logic [1:0] {RW_ANY, RW_RD, RW_WR, RW_ANY_ALT} rw_sel_e;

  localparam int NUM_CH = 2;
  localparam int CFG_AW = 3;
  localparam int CFG_DW = 32;

  localparam logic [CFG_AW-1:0] REG_C1_CTRL  = 3'd0;
  localparam logic [CFG_AW-1:0] REG_C1_ADDR  = 3'd1;
  localparam logic [CFG_AW-1:0] REG_C1_DATA  = 3'd2;
  localparam logic [CFG_AW-1:0] REG_C2_CTRL  = 3'd3;
  localparam logic [CFG_AW-1:0] REG_C2_ADDR  = 3'd4;
  localparam logic [CFG_AW-1:0] REG_STAT_CLR = 3'd5;

  localparam int MASK_STEP     = 4;
  localparam int MASK_MAX_CODE = 5;

  // 1 = bit compared, 0 = bit ignored
  function automatic logic [31:0] addr_keep(input logic [2:0] code);
    logic [31:0] k;
    k = '1;
    if (code != 3'd0 && int'(code) <= MASK_MAX_CODE)
      k = 32'hFFFF_FFFF << (MASK_STEP * int'(code));
    return k;
  endfunction

endpackage

// File: rtl/bkpt_cfg.sv
module bkpt_cfg
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [CFG_AW-1:0]   addr_i,
  input  logic [CFG_DW-1:0]   wdata_i,
  output logic                c1_en_o,
  output logic [2:0]          c1_mask_o,
  output cyc_sel_e            c1_cyc_o,
  output size_sel_e           c1_size_o,
  output rw_sel_e             c1_rw_o,
  output logic                c1_dcmp_o,
  output logic [ADDR_W-1:0]   c1_addr_o,
  output logic [DATA_W-1:0]   c1_data_o,
  output logic                c2_en_o,
  output logic [ADDR_W-1:0]   c2_addr_o,
  output logic                c2_clr_o,
  output logic [NUM_CH-1:0]   stat_clr_o
);

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_en_o   <= 1'b0;
      c1_mask_o <= '0;
      c1_cyc_o  <= CYC_ANY;
      c1_size_o <= SZ_ANY;
      c1_rw_o   <= RW_ANY;
      c1_dcmp_o <= 1'b0;
      c1_addr_o <= '0;
      c1_data_o <= '0;
      c2_en_o   <= 1'b0;
      c2_addr_o <= '0;
    end else if (we_i) begin
      case (addr_i)
        REG_C1_CTRL: begin
          c1_en_o   <= wdata_i[0];
          c1_mask_o <= wdata_i[3:1];
          c1_cyc_o  <= cyc_sel_e'(wdata_i[5:4]);
          c1_size_o <= size_sel_e'(wdata_i[7:6]);
          c1_rw_o   <= rw_sel_e'(wdata_i[9:8]);
          c1_dcmp_o <= wdata_i[10];
        end
        REG_C1_ADDR: c1_addr_o <= wdata_i[ADDR_W-1:0];
        REG_C1_DATA: c1_data_o <= wdata_i[DATA_W-1:0];
        REG_C2_CTRL: c2_en_o   <= wdata_i[0];
        REG_C2_ADDR: c2_addr_o <= wdata_i[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  assign c2_clr_o   = we_i && (addr_i == REG_C2_CTRL || addr_i == REG_C2_ADDR);
  assign stat_clr_o = (we_i && addr_i == REG_STAT_CLR) ? wdata_i[NUM_CH-1:0] : '0;

  p_c2_write_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_C2_ADDR) |=> (c2_addr_o == $past(wdata_i[ADDR_W-1:0])));

endmodule

// File: rtl/bkpt_full_cmp.sv
module bkpt_full_cmp
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              en_i,
  input  logic [2:0]        mask_i,
  input  cyc_sel_e          cyc_i,
  input  size_sel_e         size_i,
  input  rw_sel_e           rw_i,
  input  logic              dcmp_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  input  logic              bus_valid_i,
  input  logic              bus_fetch_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [LANES-1:0]  bus_be_i,
  output logic              hit_o
);

  localparam logic [LANES-1:0] LO_BE = LANES'(1);
  localparam logic [LANES-1:0] HI_BE = LO_BE << (LANES - 1);

  logic [ADDR_W-1:0] keep;
  logic              addr_ok, cyc_ok, size_ok, rw_ok, data_ok;
  logic [LANES-1:0]  lane_ok;

  assign keep    = ADDR_W'(addr_keep(mask_i));
  assign addr_ok = ((bus_addr_i ^ cfg_addr_i) & keep) == '0;

  always_comb begin
    unique case (cyc_i)
      CYC_FETCH: cyc_ok = bus_fetch_i;
      CYC_DATA:  cyc_ok = !bus_fetch_i;
      default:   cyc_ok = 1'b1;
    endcase
  end

  always_comb begin
    unique case (size_i)
      SZ_LO:   size_ok = (bus_be_i == LO_BE);
      SZ_HI:   size_ok = (bus_be_i == HI_BE);
      SZ_WORD: size_ok = &bus_be_i;
      default: size_ok = 1'b1;
    endcase
  end

  always_comb begin
    unique case (rw_i)
      RW_RD:   rw_ok = !bus_write_i;
      RW_WR:   rw_ok = bus_write_i;
      default: rw_ok = 1'b1;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_ok[g] = !bus_be_i[g] || (bus_data_i[8*g +: 8] == cfg_data_i[8*g +: 8]);
  end

  assign data_ok = !dcmp_i || (&lane_ok);
  assign hit_o   = en_i && bus_valid_i && addr_ok && cyc_ok && size_ok && rw_ok && data_ok;

endmodule

// File: rtl/bkpt_post_cmp.sv
module bkpt_post_cmp #(
  parameter int ADDR_W = 24,
  parameter int TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              clr_i,
  input  logic              bus_valid_i,
  input  logic              bus_fetch_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic              retire_valid_i,
  input  logic [TAG_W-1:0]  retire_tag_i,
  input  logic              flush_i,
  output logic              hit_o
);

  logic             pend_q;
  logic [TAG_W-1:0] tag_q;
  logic             cap;

  assign cap   = en_i && bus_valid_i && bus_fetch_i && (bus_addr_i == cfg_addr_i);
  assign hit_o = pend_q && retire_valid_i && (retire_tag_i == tag_q) && !flush_i;

  // flush / reconfigure beats a new capture; a new capture replaces an older one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      tag_q  <= '0;
    end else if (flush_i || clr_i) begin
      pend_q <= 1'b0;
    end else if (cap) begin
      pend_q <= 1'b1;
      tag_q  <= bus_tag_i;
    end else if (hit_o) begin
      pend_q <= 1'b0;
    end
  end

  p_arm_on_fetch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && bus_valid_i && bus_fetch_i && bus_addr_i == cfg_addr_i && !flush_i && !clr_i)
      |=> (pend_q && tag_q == $past(bus_tag_i)));

  p_flush_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i || clr_i) |=> !pend_q);

  p_flush_blocks_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !hit_o);

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_fetch_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [LANES-1:0]  bus_be_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic              retire_valid_i,
  input  logic [TAG_W-1:0]  retire_tag_i,
  input  logic              flush_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  output logic              brk_req_o,
  output logic [NUM_CH-1:0] brk_status_o
);

  logic              c1_en, c1_dcmp, c2_en, c2_clr;
  logic [2:0]        c1_mask;
  cyc_sel_e          c1_cyc;
  size_sel_e         c1_size;
  rw_sel_e           c1_rw;
  logic [ADDR_W-1:0] c1_addr, c2_addr;
  logic [DATA_W-1:0] c1_data;
  logic [NUM_CH-1:0] stat_clr, hit;
  logic              brk_q;
  logic [NUM_CH-1:0] stat_q;

  bkpt_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .c1_en_o   (c1_en),
    .c1_mask_o (c1_mask),
    .c1_cyc_o  (c1_cyc),
    .c1_size_o (c1_size),
    .c1_rw_o   (c1_rw),
    .c1_dcmp_o (c1_dcmp),
    .c1_addr_o (c1_addr),
    .c1_data_o (c1_data),
    .c2_en_o   (c2_en),
    .c2_addr_o (c2_addr),
    .c2_clr_o  (c2_clr),
    .stat_clr_o(stat_clr)
  );

  bkpt_full_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ch1 (
    .en_i       (c1_en),
    .mask_i     (c1_mask),
    .cyc_i      (c1_cyc),
    .size_i     (c1_size),
    .rw_i       (c1_rw),
    .dcmp_i     (c1_dcmp),
    .cfg_addr_i (c1_addr),
    .cfg_data_i (c1_data),
    .bus_valid_i, .bus_fetch_i, .bus_write_i,
    .bus_addr_i, .bus_data_i, .bus_be_i,
    .hit_o      (hit[0])
  );

  bkpt_post_cmp #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_ch2 (
    .clk_i, .rst_ni,
    .en_i       (c2_en),
    .cfg_addr_i (c2_addr),
    .clr_i      (c2_clr),
    .bus_valid_i, .bus_fetch_i, .bus_addr_i, .bus_tag_i,
    .retire_valid_i, .retire_tag_i, .flush_i,
    .hit_o      (hit[1])
  );

  // match wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      brk_q  <= |hit;
      stat_q <= (stat_q & ~stat_clr) | hit;
    end
  end

  assign brk_req_o    = brk_q;
  assign brk_status_o = stat_q;

  p_brk_sets_status_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |-> (|brk_status_o));

  p_status_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_status_o[0] && !(cfg_we_i && cfg_addr_i == REG_STAT_CLR && cfg_wdata_i[0]))
      |=> brk_status_o[0]);

  p_disabled_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_req_o && !$past(hit[1])) |-> $past(c1_en && bus_valid_i));

  p_fetch_qual_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_req_o && !$past(hit[1]) && $past(c1_cyc == CYC_FETCH)) |-> $past(bus_fetch_i));

  p_word_qual_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_req_o && !$past(hit[1]) && $past(c1_size == SZ_WORD)) |-> $past(&bus_be_i));

  p_write_qual_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_req_o && !$past(hit[1]) && $past(c1_rw == RW_WR)) |-> $past(bus_write_i));

endmodule

// File: tb/bkpt_unit_bench.sv
module bkpt_unit_bench;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          bus_valid, bus_fetch, bus_write, ret_v, flush, cfg_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic [1:0]    bus_be;
  logic [TW-1:0] bus_tag, ret_tag;
  logic [2:0]    cfg_addr;
  logic [31:0]   cfg_wdata;
  logic          brk;
  logic [1:0]    stat;

  bkpt_unit u_bkpt_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bus_valid), .bus_fetch_i(bus_fetch), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_data_i(bus_data), .bus_be_i(bus_be), .bus_tag_i(bus_tag),
    .retire_valid_i(ret_v), .retire_tag_i(ret_tag), .flush_i(flush),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .brk_req_o(brk), .brk_status_o(stat)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0]   m_c1ctrl, m_c1addr, m_c1data, m_c2ctrl, m_c2addr;
  logic          m_pend, m_brk;
  logic [TW-1:0] m_tag;
  logic [1:0]    m_stat;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] keep_of(input logic [2:0] code);
    if (code >= 3'd1 && code <= 3'd5) return {AW{1'b1}} << (4 * int'(code));
    return {AW{1'b1}};
  endfunction

  function automatic logic ch1_match();
    logic [2:0] code;
    logic [1:0] cy, sz, rw;
    logic a_ok, c_ok, s_ok, r_ok, d_ok;
    code = m_c1ctrl[3:1]; cy = m_c1ctrl[5:4]; sz = m_c1ctrl[7:6]; rw = m_c1ctrl[9:8];
    a_ok = ((bus_addr ^ m_c1addr[AW-1:0]) & keep_of(code)) == '0;
    c_ok = (cy == 2'd1) ? bus_fetch : (cy == 2'd2) ? !bus_fetch : 1'b1;
    s_ok = (sz == 2'd0) ? 1'b1 : (sz == 2'd1) ? (bus_be == 2'b01) :
           (sz == 2'd2) ? (bus_be == 2'b10) : (bus_be == 2'b11);
    r_ok = (rw == 2'd1) ? !bus_write : (rw == 2'd2) ? bus_write : 1'b1;
    d_ok = !m_c1ctrl[10] ||
           ((!bus_be[0] || bus_data[7:0] == m_c1data[7:0]) &&
            (!bus_be[1] || bus_data[15:8] == m_c1data[15:8]));
    return bus_valid && m_c1ctrl[0] && a_ok && c_ok && s_ok && r_ok && d_ok;
  endfunction

  task automatic idle_inputs();
    bus_valid = 0; bus_fetch = 0; bus_write = 0; bus_addr = '0; bus_data = '0;
    bus_be = 2'b00; bus_tag = '0; ret_v = 0; ret_tag = '0; flush = 0;
    cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
  endtask

  // inputs already driven; advance one edge, update model, compare
  task automatic cyc(input string req);
    logic h1, h2, cap, c2clr;
    logic [1:0] clrb;
    h1 = ch1_match();
    h2 = m_pend && ret_v && (ret_tag == m_tag) && !flush;
    cap = m_c2ctrl[0] && bus_valid && bus_fetch && (bus_addr == m_c2addr[AW-1:0]);
    c2clr = cfg_we && (cfg_addr == 3'd3 || cfg_addr == 3'd4);
    clrb = (cfg_we && cfg_addr == 3'd5) ? cfg_wdata[1:0] : 2'b00;
    @(posedge clk); #1;
    if (flush || c2clr) m_pend = 0;
    else if (cap) begin m_pend = 1; m_tag = bus_tag; end
    else if (h2) m_pend = 0;
    m_brk = h1 || h2;
    m_stat = (m_stat & ~clrb) | {h2, h1};
    if (cfg_we) begin
      case (cfg_addr)
        3'd0: m_c1ctrl = cfg_wdata & 32'h7FF;
        3'd1: m_c1addr = cfg_wdata & 32'hFF_FFFF;
        3'd2: m_c1data = cfg_wdata & 32'hFFFF;
        3'd3: m_c2ctrl = cfg_wdata & 32'h1;
        3'd4: m_c2addr = cfg_wdata & 32'hFF_FFFF;
        default: ;
      endcase
    end
    check(32'(brk), 32'(m_brk), req, "brk_req model");
    check(32'(stat), 32'(m_stat), req, "status model");
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    cyc("cfg");
  endtask

  task automatic beat(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic f,
                      input logic w, input logic [1:0] be, input logic [TW-1:0] t);
    bus_valid = 1; bus_addr = a; bus_data = d; bus_fetch = f; bus_write = w; bus_be = be; bus_tag = t;
  endtask

  initial begin
    idle_inputs();
    m_c1ctrl = 0; m_c1addr = 0; m_c1data = 0; m_c2ctrl = 0; m_c2addr = 0;
    m_pend = 0; m_brk = 0; m_tag = '0; m_stat = 0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(32'(brk), 0, "R10", "brk after reset");
    check(32'(stat), 0, "R10", "status after reset");
    rst_n = 1;
    @(negedge clk);

    // R1 mask
    wr(3'd1, 32'h123456);
    wr(3'd0, 32'h5);
    beat(24'h1234AB, 16'h0, 0, 0, 2'b11, 0); cyc("R1");
    check(32'(brk), 1, "R1", "mask code 2 hit");
    cyc("R6"); check(32'(brk), 0, "R6", "pulse one cycle");
    beat(24'h1235AB, 16'h0, 0, 0, 2'b11, 0); cyc("R1");
    check(32'(brk), 0, "R1", "mask code 2 miss");
    wr(3'd0, 32'hD);
    beat(24'h123457, 16'h0, 0, 0, 2'b11, 0); cyc("R1");
    check(32'(brk), 0, "R1", "code 6 exact miss");
    beat(24'h123456, 16'h0, 0, 0, 2'b11, 0); cyc("R1");
    check(32'(brk), 1, "R1", "code 6 exact hit");
    wr(3'd5, 32'h3);
    check(32'(stat), 0, "R9", "status cleared");

    // R2 cycle select
    wr(3'd0, 32'h11);
    beat(24'h123456, 16'h0, 0, 0, 2'b11, 0); cyc("R2");
    check(32'(brk), 0, "R2", "data beat under fetch-only");
    beat(24'h123456, 16'h0, 1, 0, 2'b11, 0); cyc("R2");
    check(32'(brk), 1, "R2", "fetch beat under fetch-only");

    // R3 size select
    wr(3'd0, 32'h41);
    beat(24'h123456, 16'h0, 0, 0, 2'b10, 0); cyc("R3");
    check(32'(brk), 0, "R3", "upper strobe under lower-byte");
    beat(24'h123456, 16'h0, 0, 0, 2'b01, 0); cyc("R3");
    check(32'(brk), 1, "R3", "lower strobe under lower-byte");

    // R4 read/write select
    wr(3'd0, 32'h201);
    beat(24'h123456, 16'h0, 0, 0, 2'b11, 0); cyc("R4");
    check(32'(brk), 0, "R4", "read under write-only");
    beat(24'h123456, 16'h0, 0, 1, 2'b11, 0); cyc("R4");
    check(32'(brk), 1, "R4", "write under write-only");

    // R5 data lanes
    wr(3'd2, 32'hBEEF);
    wr(3'd0, 32'h481);
    beat(24'h123456, 16'hBE00, 0, 0, 2'b10, 0); cyc("R5");
    check(32'(brk), 1, "R5", "upper lane equal");
    beat(24'h123456, 16'hBF00, 0, 0, 2'b10, 0); cyc("R5");
    check(32'(brk), 0, "R5", "upper lane differs");

    // R6 disabled
    wr(3'd0, 32'h0);
    beat(24'h123456, 16'h0, 0, 0, 2'b11, 0); cyc("R6");
    check(32'(brk), 0, "R6", "disabled channel");

    // R7 post-execution
    wr(3'd4, 32'h000100);
    wr(3'd3, 32'h1);
    wr(3'd5, 32'h3);
    beat(24'h000100, 16'h0, 1, 0, 2'b11, 4'd5); cyc("R7");
    check(32'(brk), 0, "R7", "no break at fetch");
    ret_v = 1; ret_tag = 4'd3; cyc("R7");
    check(32'(brk), 0, "R7", "other tag retires");
    ret_v = 1; ret_tag = 4'd5; cyc("R7");
    check(32'(brk), 1, "R7", "tagged retire");
    check(32'(stat), 2, "R7", "channel 2 status");
    ret_v = 1; ret_tag = 4'd5; cyc("R7");
    check(32'(brk), 0, "R7", "retire consumed match");
    beat(24'h000100, 16'h0, 0, 0, 2'b11, 4'd6); cyc("R7");
    ret_v = 1; ret_tag = 4'd6; cyc("R7");
    check(32'(brk), 0, "R7", "data beat does not arm");

    // R8 flush and reconfigure
    beat(24'h000100, 16'h0, 1, 0, 2'b11, 4'd7); cyc("R8");
    flush = 1; ret_v = 1; ret_tag = 4'd7; cyc("R8");
    check(32'(brk), 0, "R8", "retire with flush");
    ret_v = 1; ret_tag = 4'd7; cyc("R8");
    check(32'(brk), 0, "R8", "after flush");
    beat(24'h000100, 16'h0, 1, 0, 2'b11, 4'd2); cyc("R8");
    wr(3'd3, 32'h1);
    ret_v = 1; ret_tag = 4'd2; cyc("R8");
    check(32'(brk), 0, "R8", "after reconfigure");

    // R9 both channels and clear priority
    wr(3'd1, 32'h000100);
    wr(3'd0, 32'h1);
    beat(24'h000100, 16'h0, 1, 0, 2'b11, 4'd1); cyc("R9");
    wr(3'd5, 32'h3);
    check(32'(stat), 0, "R9", "clear both");
    beat(24'h000100, 16'h0, 0, 0, 2'b11, 4'd0); ret_v = 1; ret_tag = 4'd1; cyc("R9");
    check(32'(stat), 3, "R9", "both channels same cycle");
    wr(3'd5, 32'h1);
    check(32'(stat), 2, "R9", "partial clear");
    beat(24'h000100, 16'h0, 0, 0, 2'b11, 4'd0);
    cfg_we = 1; cfg_addr = 3'd5; cfg_wdata = 32'h3; cyc("R9");
    check(32'(stat), 1, "R9", "set wins over clear");

    // random mix, compared against the model (R1-style tags per requirement in messages)
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] base;
      base = 24'h3C5A00;
      if ($urandom_range(0, 39) == 0) begin
        cfg_we = 1; cfg_addr = 3'($urandom_range(0, 7));
        case (cfg_addr)
          3'd1, 3'd4: cfg_wdata = 32'(base) + 32'($urandom_range(0, 1) * 2);
          3'd2: cfg_wdata = $urandom_range(0, 1) ? 32'h00A55A : $urandom;
          3'd0: cfg_wdata = $urandom | 32'h1;
          default: cfg_wdata = $urandom;
        endcase
      end
      if ($urandom_range(0, 2) != 0) begin
        case ($urandom_range(0, 3))
          0: bus_addr = base;
          1: bus_addr = base ^ AW'($urandom & 32'hF);
          2: bus_addr = base ^ AW'($urandom & 32'hFFFFF);
          default: bus_addr = AW'($urandom);
        endcase
        bus_valid = 1; bus_fetch = 1'($urandom); bus_write = 1'($urandom);
        bus_be = 2'($urandom); bus_tag = TW'($urandom_range(0, 3));
        bus_data = $urandom_range(0, 1) ? 16'hA55A : 16'($urandom);
      end
      if ($urandom_range(0, 2) == 0) begin ret_v = 1; ret_tag = TW'($urandom_range(0, 3)); end
      if ($urandom_range(0, 29) == 0) flush = 1;
      if ($urandom_range(0, 49) == 0) begin cfg_we = 1; cfg_addr = 3'd5; cfg_wdata = $urandom; end
      cyc("R1-R9 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule